// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer that hangs off a simple 32-bit register bus made of an address, a write strobe, write data and combinational read data. Software programs a prescale divisor and a 16-bit reload count. It then sets an enable bit. If software does not kick the timer before the count runs out, the block raises a one-cycle reset request. The count is then reloaded on its own, so an ignored watchdog keeps firing at a steady period.

Two features guard against runaway code. First, a write is accepted only when the upper half of the data word carries a fixed 16-bit key. Second, values written to the divisor and reload registers are held as shadows. They reach the live timer only when a refresh write flips the matching two-bit field between code 1 and code 2. The refresh register has three such fields: one commits the divisor, one reloads the counter (this is the kick) and one is kept for an interrupt value. That last field holds no state in this block. Software normally inverts all six low bits at once to refresh everything.

Top module: `kwdt_top`

## Requirements
- R1: A write whose bits 31:16 differ from 0x1234 changes no register and has no effect on the timer.
- R2: Register offsets: 0x04 holds the divisor configuration, 0x08 the reload count, 0x18 the refresh fields and 0x1C the start control. A read returns the stored 16 bits with bits 31:16 zero. Any other offset reads zero.
- R3: After reset, the configuration reads 0x0F00 (divide by 16), the reload count reads 0xFFFF, the refresh register reads 0x0015 (every field at code 1), the start register reads 0 and the reset output is low.
- R4: Writes to the configuration and reload registers do not change the timer's behaviour until a matching refresh event occurs.
- R5: A refresh field produces an event only when a write changes it from 01 to 10 or from 10 to 01. Any other change, including to or from 11 or 00, produces none. The raw written value is always stored.
- R6: Refresh bits 5:4 commit configuration bits 15:8 as the live divisor. Bits 3:2 load the reload count into the counter and restart the prescaler. Bits 1:0 have no effect on counting.
- R7: With divisor field d and a committed count N of at least 1, the reset output pulses exactly N*(d+1) clock edges after the edge that enabled the timer or reloaded the counter.
- R8: The reset output is a single-cycle pulse. The counter then reloads from the committed count, so pulses repeat every N*(d+1) cycles while the timer stays enabled.
- R9: Start bit 0 enables counting. While it is 0, the counter holds its value and no pulse occurs. Start bits 15:1 are stored and read back with no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data: key in 31:16, payload in 15:0 |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wdt_rst | output | 1 | One-cycle reset request on expiry |

## Verification
The bench counts the exact edge of each expiry pulse, so a prescaler that is off by one cycle or a counter that expires one tick early shows up as a pulse in the wrong cycle. It writes a new divisor but commits only the reload field. A design that let shadows leak into the live timer would then fire after 4 cycles instead of 32. It drives refresh fields through 11 and back to 01 and toggles only the interrupt field. A design that decoded any bit change as a kick would push the expiry out, and the bench catches that through the pulse count. Bad-key writes, a stop followed by 40 idle cycles, and a restart check that rejected writes leave the registers unchanged and that a stopped timer stays silent and resumes with a full period.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
   localparam logic [7:0] OFS_CFG   = 8'h04;
   localparam logic [7:0] OFS_LOAD  = 8'h08;
   localparam logic [7:0] OFS_REFR  = 8'h18;
   localparam logic [7:0] OFS_START = 8'h1C;

   localparam int NUM_GRP = 3;
   localparam int GRP_INT = 0;
   localparam int GRP_CNT = 1;
   localparam int GRP_CFG = 2;

   localparam logic [1:0] CODE_A = 2'b01;
   localparam logic [1:0] CODE_B = 2'b10;

   localparam logic [15:0] REFR_RST = 16'h0015;
   localparam int          DIV_LSB  = 8;

   typedef struct packed {
      logic commit_cfg;
      logic reload_cnt;
   } kwdt_evt_t;
endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int          ADDR_W  = 8,
   parameter int          DIV_W   = 8,
   parameter int          CNT_W   = 16,
   parameter logic [15:0] KEY     = 16'h1234,
   parameter logic [15:0] CFG_RST = 16'h0F00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [DIV_W-1:0]  cfg_div,
   output logic [CNT_W-1:0]  load_val,
   output logic              run_en,
   output kwdt_evt_t         evt
);
   logic [15:0] cfg_q, load_q, refr_q, start_q;
   logic        wr_ok;
   logic [NUM_GRP-1:0] flip;

   assign wr_ok = bus_we && (bus_wdata[31:16] == KEY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= CFG_RST;
         load_q  <= 16'hFFFF;
         refr_q  <= REFR_RST;
         start_q <= 16'h0000;
      end else if (wr_ok) begin
         case (bus_addr)
            ADDR_W'(OFS_CFG):   cfg_q   <= bus_wdata[15:0];
            ADDR_W'(OFS_LOAD):  load_q  <= bus_wdata[15:0];
            ADDR_W'(OFS_REFR):  refr_q  <= bus_wdata[15:0];
            ADDR_W'(OFS_START): start_q <= bus_wdata[15:0];
            default: ;
         endcase
      end
   end

   // One flip detector per refresh field
   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic [1:0] old_c, new_c;
      assign old_c = refr_q[2*g +: 2];
      assign new_c = bus_wdata[2*g +: 2];
      assign flip[g] = wr_ok && (bus_addr == ADDR_W'(OFS_REFR)) &&
                       (((old_c == CODE_A) && (new_c == CODE_B)) ||
                        ((old_c == CODE_B) && (new_c == CODE_A)));

      // R5: an event always leaves the field at a valid code
      p_grp_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
         flip[g] |=> (refr_q[2*g +: 2] == CODE_A || refr_q[2*g +: 2] == CODE_B));
   end

   assign evt.commit_cfg = flip[GRP_CFG];
   assign evt.reload_cnt = flip[GRP_CNT];

   assign cfg_div  = cfg_q[DIV_LSB +: DIV_W];
   assign load_val = load_q[CNT_W-1:0];
   assign run_en   = start_q[0];

   always_comb begin
      case (bus_addr)
         ADDR_W'(OFS_CFG):   bus_rdata = {16'h0000, cfg_q};
         ADDR_W'(OFS_LOAD):  bus_rdata = {16'h0000, load_q};
         ADDR_W'(OFS_REFR):  bus_rdata = {16'h0000, refr_q};
         ADDR_W'(OFS_START): bus_rdata = {16'h0000, start_q};
         default:            bus_rdata = 32'h0;
      endcase
   end

   // R1: a keyless write leaves every register as it was
   p_reject_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_wdata[31:16] != KEY) |=>
         ($stable(cfg_q) && $stable(load_q) && $stable(refr_q) && $stable(start_q)));
endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
   parameter int               DIV_W   = 8,
   parameter logic [DIV_W-1:0] DIV_RST = 8'd15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             commit,
   input  logic             restart,
   input  logic [DIV_W-1:0] div_next,
   output logic             tick
);
   logic [DIV_W-1:0] div_live, pre_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_live <= DIV_RST;
      else if (commit) div_live <= div_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           pre_q <= '0;
      else if (!en || commit || restart)    pre_q <= '0;
      else if (pre_q == div_live)           pre_q <= '0;
      else                                  pre_q <= pre_q + 1'b1;
   end

   assign tick = en && (pre_q == div_live);

   // R7: prescale phase never passes the live divisor
   p_pre_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= div_live);
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
   parameter int               CNT_W   = 16,
   parameter logic [CNT_W-1:0] CNT_RST = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic             reload,
   input  logic [CNT_W-1:0] load_val,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q, rel_q;
   logic             last;

   assign last = (cnt_q <= CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_RST;
         rel_q  <= CNT_RST;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (reload) begin
            rel_q <= load_val;
            cnt_q <= load_val;
         end else if (tick) begin
            if (last) begin
               cnt_q  <= rel_q;
               expire <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   // R9: a stopped timer holds its count
   p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !reload) |=> $stable(cnt_q));
   // R8: expiry only while enabled, and the count restarts from the committed value
   p_expire_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> $past(en));
   p_expire_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> (cnt_q == rel_q));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
   import kwdt_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          DIV_W       = 8,
   parameter int          CNT_W       = 16,
   parameter int          DEF_DIVISOR = 16,
   parameter logic [15:0] KEY         = 16'h1234
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              wdt_rst
);
   localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DEF_DIVISOR - 1);
   localparam logic [15:0]      CFG_RST = 16'(DEF_DIVISOR - 1) << DIV_LSB;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("ADDR_W must reach offset 0x1C");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must be 1..8");
   end
   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must be 2..16");
   end
   if (DEF_DIVISOR < 1 || DEF_DIVISOR > (1 << DIV_W)) begin : g_bad_def
      $error("DEF_DIVISOR out of range");
   end

   logic [DIV_W-1:0] cfg_div;
   logic [CNT_W-1:0] load_val;
   logic             run_en, tick;
   kwdt_evt_t        evt;

   kwdt_regs #(
      .ADDR_W(ADDR_W), .DIV_W(DIV_W), .CNT_W(CNT_W), .KEY(KEY), .CFG_RST(CFG_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_div(cfg_div),
      .load_val(load_val), .run_en(run_en), .evt(evt)
   );

   kwdt_prescaler #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(run_en), .commit(evt.commit_cfg),
      .restart(evt.reload_cnt), .div_next(cfg_div), .tick(tick)
   );

   kwdt_counter #(.CNT_W(CNT_W), .CNT_RST('1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(run_en), .tick(tick),
      .reload(evt.reload_cnt), .load_val(load_val), .expire(wdt_rst)
   );
endmodule

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        wdt_rst;

   int tests_run = 0;
   int tests_fail = 0;
   int pulses = 0;

   localparam logic [7:0] A_CFG = 8'h04, A_LOAD = 8'h08, A_REFR = 8'h18, A_START = 8'h1C;

   always #10 clk = ~clk;

   kwdt_top u_kwdt_top (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst(wdt_rst)
   );

   always @(negedge clk) if (rst_n && wdt_rst) pulses++;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests_run++;
      if (act !== exp) begin
         tests_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      bus_we = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      pulses = 0;
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d,
                     input logic [15:0] key = 16'h1234);
      bus_addr  = a;
      bus_wdata = {key, d};
      bus_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   // pulse expected on the k-th rising edge from now
   task automatic expect_pulse_in(input int k, input string req);
      repeat (k - 1) @(posedge clk);
      @(negedge clk); chk({req, " before expiry"}, {31'h0, wdt_rst}, 32'h0);
      @(posedge clk);
      @(negedge clk); chk({req, " expiry pulse"}, {31'h0, wdt_rst}, 32'h1);
      @(posedge clk);
      @(negedge clk); chk({req, " pulse one cycle"}, {31'h0, wdt_rst}, 32'h0);
   endtask

   // divisor 2, count 3, all fields refreshed: refresh reads 0x2A
   task automatic setup_small();
      do_reset();
      wr(A_CFG, 16'h0100);
      wr(A_LOAD, 16'h0003);
      wr(A_REFR, 16'h002A);
   endtask

   task automatic t_reset();
      do_reset();
      rd(A_CFG,   32'h0000_0F00, "R3 cfg");
      rd(A_LOAD,  32'h0000_FFFF, "R3 load");
      rd(A_REFR,  32'h0000_0015, "R3 refresh");
      rd(A_START, 32'h0000_0000, "R3 start");
      chk("R3 output low", {31'h0, wdt_rst}, 32'h0);
      rd(8'h0C,   32'h0000_0000, "R2 unmapped");
   endtask

   task automatic t_key();
      do_reset();
      wr(A_LOAD, 16'h0005, 16'hABCD);
      rd(A_LOAD, 32'h0000_FFFF, "R1 load keyless");
      wr(A_START, 16'h0001, 16'h1235);
      rd(A_START, 32'h0000_0000, "R1 start keyless");
      wr(A_REFR, 16'h002A, 16'h0000);
      rd(A_REFR, 32'h0000_0015, "R1 refresh keyless");
      repeat (20) @(posedge clk);
      @(negedge clk);
      chk("R1 no pulse", pulses, 0);
      wr(A_LOAD, 16'h1234);
      rd(A_LOAD, 32'h0000_1234, "R2 load readback");
   endtask

   task automatic t_shadow();
      do_reset();
      wr(A_CFG, 16'h0100);
      wr(A_LOAD, 16'h0002);
      rd(A_CFG, 32'h0000_0100, "R2 cfg readback");
      wr(A_REFR, 16'h0019);          // reload field only
      wr(A_START, 16'h0001);
      expect_pulse_in(32, "R4 divisor not committed");
      expect_pulse_in(31, "R8 periodic");
      wr(A_REFR, 16'h0029);          // config field only
      expect_pulse_in(4, "R6 divisor committed");
      rd(A_REFR, 32'h0000_0029, "R2 refresh readback");
      chk("R8 pulse count", pulses, 3);
   endtask

   task automatic t_main();
      setup_small();
      wr(A_START, 16'h0001);
      expect_pulse_in(6, "R7 timeout");
      expect_pulse_in(5, "R8 periodic");
   endtask

   task automatic t_kick();
      setup_small();
      wr(A_START, 16'h0001);
      repeat (3) @(posedge clk);
      @(negedge clk);
      wr(A_REFR, 16'h0026);          // reload field 10 -> 01
      expect_pulse_in(6, "R6 kick restarts");
      chk("R6 no early pulse", pulses, 1);
   endtask

   task automatic t_groups();
      setup_small();
      wr(A_START, 16'h0001);
      wr(A_REFR, 16'h0029);          // interrupt field only
      wr(A_REFR, 16'h002D);          // reload field 10 -> 11
      wr(A_REFR, 16'h0025);          // reload field 11 -> 01
      expect_pulse_in(3, "R5 no event via 11");
      chk("R6 interrupt field inert", pulses, 1);
      rd(A_REFR, 32'h0000_0025, "R5 raw stored");
   endtask

   task automatic t_stop();
      setup_small();
      wr(A_START, 16'h0001);
      wr(A_START, 16'h00A4);
      repeat (40) @(posedge clk);
      @(negedge clk);
      chk("R9 stopped silent", pulses, 0);
      rd(A_START, 32'h0000_00A4, "R9 start readback");
      wr(A_START, 16'h00A5);
      expect_pulse_in(6, "R9 resume");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests_fail++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_key();
      t_shadow();
      t_main();
      t_kick();
      t_groups();
      t_stop();
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
      $finish;
   end
endmodule